// File: doc/BRIEF.md
# Register Rename Table with Result-Bus Snooping

This block is the front-end register file of an out-of-order core that schedules work through reservation stations. Every architectural register has a data value, a ready flag and the tag of the reservation-station entry that will produce its next value. When an instruction is dispatched, the table looks up its two source registers. For each source it returns either a usable value or the tag to wait on. It also marks the destination register as pending under the tag of the newly allocated station entry.

The table watches every result broadcast bus at the same time. A pending register whose stored tag equals the tag on a valid bus takes that bus's data and becomes ready. The stored tag is not cleared on writeback. A broadcast that no longer matches the current producer is ignored, because the register holds only its newest tag. A source looked up in the same cycle as the broadcast that completes it is forwarded straight from the bus.

Top module: `rename_table`

## Requirements
- R1: After a synchronous active-low reset, every register reads as ready with value zero and tag zero.
- R2: A source lookup of a ready register returns ready=1 and the stored value in the same cycle, with no register delay.
- R3: A source lookup of a pending register returns ready=0 and the stored producer tag on the tag output.
- R4: When dispatch is valid, the destination register reads as pending from the next cycle on, with the tag that was presented with the dispatch.
- R5: A pending register whose stored tag equals the tag of any bus with its valid bit set takes that bus's data and reads as ready from the next cycle on.
- R6: All broadcast buses, numbered 0 to 7, are compared every cycle. If several buses match one register in the same cycle, the lowest-numbered bus supplies the data.
- R7: Writeback leaves the stored tag unchanged. The tag output always shows the stored tag, whether the register is ready or pending.
- R8: A ready register ignores broadcasts, including one whose tag equals its stale stored tag. Its value is kept.
- R9: After a register is renamed to a newer tag, a broadcast carrying the older tag is ignored, and the register stays pending.
- R10: If a register is renamed in the same cycle that a broadcast matches its current tag, the rename wins. The register reads as pending with the new tag in the next cycle.
- R11: A source lookup made in the same cycle as a broadcast that matches the pending register returns ready=1 and the broadcast data.
- R12: A bus whose valid bit is low is ignored, even if its tag matches a pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_valid | input | 1 | A dispatch renames a destination this cycle |
| dsp_dst | input | 5 | Destination register index |
| dsp_tag | input | 7 | Reservation-station tag of the new producer |
| rd0_idx | input | 5 | First source register index |
| rd1_idx | input | 5 | Second source register index |
| rd0_ready | output | 1 | First source value is usable |
| rd0_value | output | 64 | First source value (stored or forwarded) |
| rd0_tag | output | 7 | First source stored tag |
| rd1_ready | output | 1 | Second source value is usable |
| rd1_value | output | 64 | Second source value (stored or forwarded) |
| rd1_tag | output | 7 | Second source stored tag |
| cdb_valid | input | 8 | Valid bit per broadcast bus |
| cdb_tag | input | 56 | Tags, bus b in bits [7b+6:7b] |
| cdb_data | input | 512 | Data, bus b in bits [64b+63:64b] |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a rename and a completing broadcast hit the same register. In the second, a source lookup and the broadcast that completes that source arrive together. The bench drives a rename and a broadcast of the old tag in one cycle, then reads the register in the next cycle and expects it to be pending under the new tag. For forwarding, it reads a pending source while the matching bus is valid and expects ready and the bus data in that same cycle. It then expects the same value from storage in the following cycle. It also checks that an older tag arriving after a second rename does not complete the register, and that two buses matching at once resolve to the lower-numbered bus.

// File: rtl/rat_pkg.sv
// Package: default sizes and the per-entry update action shared by the table.
// Assumes: the widths are overridden only via module parameters.
package rat_pkg;
    localparam int RAT_REGS   = 32;
    localparam int RAT_DATA_W = 64;
    localparam int RAT_TAG_W  = 7;
    localparam int RAT_BUSES  = 8;

    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_RENAME = 2'd1,
        UPD_WAKE   = 2'd2
    } upd_e;
endpackage

// File: rtl/rat_bus_match.sv
// Module: compares one stored tag against every broadcast bus and selects
// the data of the lowest-numbered matching bus.
// Assumes: flattened buses, bus b occupying slice b of each vector.
module rat_bus_match #(
    parameter int NB = rat_pkg::RAT_BUSES,
    parameter int TW = rat_pkg::RAT_TAG_W,
    parameter int DW = rat_pkg::RAT_DATA_W
) (
    input  logic [TW-1:0]    cmp_tag,
    input  logic [NB-1:0]    bus_valid,
    input  logic [NB*TW-1:0] bus_tag,
    input  logic [NB*DW-1:0] bus_data,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);
    logic [NB-1:0] match;

    // One comparator per bus.
    for (genvar b = 0; b < NB; b++) begin : g_cmp
        assign match[b] = bus_valid[b] && (bus_tag[b*TW +: TW] == cmp_tag);
    end

    // Priority pick: walking downward lets the lowest index win.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (match[b]) begin
                hit      = 1'b1;
                hit_data = bus_data[b*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/rat_entry.sv
// Module: one architectural register: value, ready flag, producer tag.
// Rename has priority over a completing broadcast; only a pending entry
// can be completed; the tag survives writeback.
// Assumes: at most one rename per cycle is presented to a given entry.
module rat_entry
    import rat_pkg::*;
#(
    parameter int NB = RAT_BUSES,
    parameter int TW = RAT_TAG_W,
    parameter int DW = RAT_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren,
    input  logic [TW-1:0]    ren_tag,
    input  logic [NB-1:0]    bus_valid,
    input  logic [NB*TW-1:0] bus_tag,
    input  logic [NB*DW-1:0] bus_data,
    output logic             valid_q,
    output logic [TW-1:0]    tag_q,
    output logic [DW-1:0]    value_q,
    output logic             byp_hit,
    output logic [DW-1:0]    byp_data
);
    logic          hit;
    logic [DW-1:0] hit_data;
    upd_e          act;

    rat_bus_match #(.NB(NB), .TW(TW), .DW(DW)) u_match (
        .cmp_tag  (tag_q),
        .bus_valid(bus_valid),
        .bus_tag  (bus_tag),
        .bus_data (bus_data),
        .hit      (hit),
        .hit_data (hit_data)
    );

    // Decide this cycle's update: rename beats wake, wake needs pending.
    always_comb begin
        act = UPD_HOLD;
        if (ren)                  act = UPD_RENAME;
        else if (!valid_q && hit) act = UPD_WAKE;
    end

    // Forwarding view for same-cycle source lookups.
    assign byp_hit  = !valid_q && hit;
    assign byp_data = hit_data;

    // Entry storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b1;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            case (act)
                UPD_RENAME: begin
                    valid_q <= 1'b0;
                    tag_q   <= ren_tag;
                end
                UPD_WAKE: begin
                    valid_q <= 1'b1;
                    value_q <= hit_data;
                end
                default: ;
            endcase
        end
    end

    // R4
    rename_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren |=> (!valid_q && tag_q == $past(ren_tag)));

    // R5
    wake_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && !valid_q && hit) |=> (valid_q && value_q == $past(hit_data)));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && valid_q) |=> (valid_q && $stable(value_q)));

    // R7
    tag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ren |=> $stable(tag_q));
endmodule

// File: rtl/rat_read_port.sv
// Module: one source lookup port; selects an entry and forwards a
// same-cycle completing broadcast ahead of the stored state.
// Assumes: entry state arrives flattened, entry i in slice i.
module rat_read_port #(
    parameter int NR = rat_pkg::RAT_REGS,
    parameter int TW = rat_pkg::RAT_TAG_W,
    parameter int DW = rat_pkg::RAT_DATA_W,
    localparam int AW = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    idx,
    input  logic [NR-1:0]    valid_v,
    input  logic [NR*TW-1:0] tag_v,
    input  logic [NR*DW-1:0] value_v,
    input  logic [NR-1:0]    byp_v,
    input  logic [NR*DW-1:0] byp_data_v,
    output logic             ready,
    output logic [DW-1:0]    value,
    output logic [TW-1:0]    tag
);
    // Select stored or forwarded state of the addressed entry.
    always_comb begin
        tag = tag_v[idx*TW +: TW];
        if (byp_v[idx]) begin
            ready = 1'b1;
            value = byp_data_v[idx*DW +: DW];
        end else begin
            ready = valid_v[idx];
            value = value_v[idx*DW +: DW];
        end
    end

    // R11
    bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_v[idx] |-> ready);
endmodule

// File: rtl/rename_table.sv
// Module: top of the register rename table. Holds NR entries, performs one
// rename per cycle, serves two source lookups and snoops NB result buses.
// Assumes: tags on simultaneously valid buses are distinct in normal use.
module rename_table
    import rat_pkg::*;
#(
    parameter int NR = RAT_REGS,
    parameter int DW = RAT_DATA_W,
    parameter int TW = RAT_TAG_W,
    parameter int NB = RAT_BUSES,
    localparam int AW = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dsp_valid,
    input  logic [AW-1:0]    dsp_dst,
    input  logic [TW-1:0]    dsp_tag,
    input  logic [AW-1:0]    rd0_idx,
    input  logic [AW-1:0]    rd1_idx,
    output logic             rd0_ready,
    output logic [DW-1:0]    rd0_value,
    output logic [TW-1:0]    rd0_tag,
    output logic             rd1_ready,
    output logic [DW-1:0]    rd1_value,
    output logic [TW-1:0]    rd1_tag,
    input  logic [NB-1:0]    cdb_valid,
    input  logic [NB*TW-1:0] cdb_tag,
    input  logic [NB*DW-1:0] cdb_data
);
    logic [NR-1:0]    valid_v;
    logic [NR*TW-1:0] tag_v;
    logic [NR*DW-1:0] value_v;
    logic [NR-1:0]    byp_v;
    logic [NR*DW-1:0] byp_data_v;

    // One entry per architectural register.
    for (genvar i = 0; i < NR; i++) begin : g_ent
        logic ren;
        assign ren = dsp_valid && (dsp_dst == AW'(i));

        rat_entry #(.NB(NB), .TW(TW), .DW(DW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren      (ren),
            .ren_tag  (dsp_tag),
            .bus_valid(cdb_valid),
            .bus_tag  (cdb_tag),
            .bus_data (cdb_data),
            .valid_q  (valid_v[i]),
            .tag_q    (tag_v[i*TW +: TW]),
            .value_q  (value_v[i*DW +: DW]),
            .byp_hit  (byp_v[i]),
            .byp_data (byp_data_v[i*DW +: DW])
        );
    end

    rat_read_port #(.NR(NR), .TW(TW), .DW(DW)) u_rd0 (
        .clk(clk), .rst_n(rst_n), .idx(rd0_idx),
        .valid_v(valid_v), .tag_v(tag_v), .value_v(value_v),
        .byp_v(byp_v), .byp_data_v(byp_data_v),
        .ready(rd0_ready), .value(rd0_value), .tag(rd0_tag)
    );

    rat_read_port #(.NR(NR), .TW(TW), .DW(DW)) u_rd1 (
        .clk(clk), .rst_n(rst_n), .idx(rd1_idx),
        .valid_v(valid_v), .tag_v(tag_v), .value_v(value_v),
        .byp_v(byp_v), .byp_data_v(byp_data_v),
        .ready(rd1_ready), .value(rd1_value), .tag(rd1_tag)
    );

    // R4: rename through the top-level ports shows up as pending on a lookup
    rename_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && $past(rst_n)) |=> (valid_v[$past(dsp_dst)] == 1'b0));
endmodule

// File: tb/rename_table_tb.sv
`timescale 1ns/1ps
module rename_table_tb;
    localparam int NR = 32;
    localparam int DW = 64;
    localparam int TW = 7;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic dv;
    logic [4:0] dd, s0, s1;
    logic [TW-1:0] dt;
    logic r0_rdy, r1_rdy;
    logic [DW-1:0] r0_val, r1_val;
    logic [TW-1:0] r0_tag, r1_tag;
    logic [NB-1:0] bv;
    logic [NB*TW-1:0] btag;
    logic [NB*DW-1:0] bdata;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rename_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .dsp_valid(dv), .dsp_dst(dd), .dsp_tag(dt),
        .rd0_idx(s0), .rd1_idx(s1),
        .rd0_ready(r0_rdy), .rd0_value(r0_val), .rd0_tag(r0_tag),
        .rd1_ready(r1_rdy), .rd1_value(r1_val), .rd1_tag(r1_tag),
        .cdb_valid(bv), .cdb_tag(btag), .cdb_data(bdata)
    );

    // vector: {reg 5, tag 7, bus 3, data 64}
    localparam logic [78:0] VEC [6] = '{
        {5'd1,  7'd5,   3'd0, 64'h0000_0000_0000_0008},
        {5'd4,  7'd17,  3'd3, 64'h0000_0000_0000_00FF},
        {5'd31, 7'd127, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF},
        {5'd0,  7'd64,  3'd1, 64'h0123_4567_89AB_CDEF},
        {5'd6,  7'd90,  3'd5, 64'h8000_0000_0000_0001},
        {5'd12, 7'd1,   3'd2, 64'h5A5A_A5A5_3C3C_C3C3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        dv = 1'b0; dd = '0; dt = '0;
        bv = '0; btag = '0; bdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bcast(input int b, input logic [TW-1:0] t, input logic [DW-1:0] d);
        bv[b] = 1'b1;
        btag[b*TW +: TW] = t;
        bdata[b*DW +: DW] = d;
    endtask

    task automatic rename(input logic [4:0] r, input logic [TW-1:0] t);
        dv = 1'b1; dd = r; dt = t;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog: actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; s0 = '0; s1 = '0;
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register ready with zero after reset
        for (int i = 0; i < NR; i++) begin
            s0 = 5'(i); s1 = 5'(NR - 1 - i);
            #1;
            chk("R1 ready0", 64'(r0_rdy), 64'd1);
            chk("R1 value0", r0_val, 64'd0);
            chk("R1 tag0", 64'(r0_tag), 64'd0);
            chk("R1 ready1", 64'(r1_rdy), 64'd1);
            @(negedge clk);
        end

        // Vector table: rename, lookup pending, broadcast with bypass, readback
        for (int i = 0; i < 6; i++) begin
            logic [4:0] vr;
            logic [TW-1:0] vt;
            logic [2:0] vb;
            logic [DW-1:0] vd;
            {vr, vt, vb, vd} = VEC[i];
            rename(vr, vt);
            tick();
            clr();
            s0 = vr; s1 = vr;
            #1;
            chk("R3 pending", 64'(r0_rdy), 64'd0);
            chk("R4 new tag", 64'(r0_tag), 64'(vt));
            bcast(int'(vb), vt, vd);
            #1;
            chk("R11 bypass ready", 64'(r1_rdy), 64'd1);
            chk("R11 bypass value", r1_val, vd);
            tick();
            clr();
            #1;
            chk("R5 woke", 64'(r0_rdy), 64'd1);
            chk("R2 value", r0_val, vd);
            chk("R7 tag kept", 64'(r0_tag), 64'(vt));
            @(negedge clk);
        end

        // R8: ready reg 12 (stale tag 1) ignores a broadcast of tag 1
        s0 = 5'd12;
        bcast(4, 7'd1, 64'hDEAD_BEEF_0000_0000);
        tick();
        clr();
        #1;
        chk("R8 still ready", 64'(r0_rdy), 64'd1);
        chk("R8 value kept", r0_val, 64'h5A5A_A5A5_3C3C_C3C3);
        @(negedge clk);

        // R9: older tag after a second rename is ignored
        rename(5'd3, 7'd10);
        tick();
        rename(5'd3, 7'd11);
        tick();
        clr();
        bcast(0, 7'd10, 64'h1111);
        s0 = 5'd3;
        tick();
        clr();
        #1;
        chk("R9 stays pending", 64'(r0_rdy), 64'd0);
        chk("R9 newest tag", 64'(r0_tag), 64'd11);
        @(negedge clk);
        bcast(6, 7'd11, 64'h2222);
        tick();
        clr();
        #1;
        chk("R9 newest completes", r0_val, 64'h2222);
        @(negedge clk);

        // R10: rename and matching broadcast in the same cycle
        rename(5'd4, 7'd20);
        tick();
        rename(5'd4, 7'd21);
        bcast(1, 7'd20, 64'h3333);
        s0 = 5'd4;
        tick();
        clr();
        #1;
        chk("R10 rename wins", 64'(r0_rdy), 64'd0);
        chk("R10 tag", 64'(r0_tag), 64'd21);
        @(negedge clk);

        // R12: matching tag on a bus with valid low is ignored
        btag[3*TW +: TW] = 7'd21;
        bdata[3*DW +: DW] = 64'h4444;
        #1;
        chk("R12 no bypass", 64'(r0_rdy), 64'd0);
        tick();
        clr();
        #1;
        chk("R12 stays pending", 64'(r0_rdy), 64'd0);
        @(negedge clk);

        // R6: two buses match; lower-numbered bus 2 supplies data
        bcast(5, 7'd21, 64'hAAAA);
        bcast(2, 7'd21, 64'hBBBB);
        #1;
        chk("R6 bypass lowest bus", r0_val, 64'hBBBB);
        tick();
        clr();
        #1;
        chk("R6 stored lowest bus", r0_val, 64'hBBBB);
        chk("R6 ready", 64'(r0_rdy), 64'd1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule